// File: doc/BRIEF.md
# Timer-Clocked Asynchronous Serial Port

A full-duplex asynchronous serial port for a microcontroller subsystem. Every frame on the line is ten bits long: a low start bit, eight data bits with the least significant bit first, and a high stop bit. Software starts a transmission by writing a byte into the transmit buffer. It reads received bytes from a receive buffer, which sits next to a status bit holding the sampled stop bit.

The bit rate comes from overflow pulses of reload timers that live outside this block. A 2-bit select picks one of the overflow lines for the transmitter, and a second select picks one for the receiver. The chosen pulses are halved when the speed-double control is 0 and passed through unchanged when it is 1. They then drive a sixteen-phase bit counter, so one bit lasts 32 or 16 overflows. The receiver finds a start bit by its falling edge and confirms it at mid-bit. It then decides every later bit by a majority of three samples around mid-bit.

A received byte is kept only if the receive-done flag is clear and, when strict-stop checking is on, the stop bit sampled high. Software clears the two done flags through clear strobes. The interrupt output is raised while either flag is set and interrupts are enabled. A write to the transmit buffer while a frame is in flight is ignored.

Top module: `tmr_uart`

## Requirements
- R1: `tx_o` idles high. In the cycle after an accepted write, `tx_o` goes low for the start bit. The eight data bits follow, least significant bit first, and then a high stop bit.
- R2: One bit lasts 16 pulses of the selected overflow line when `speed_dbl_i` = 1 and 32 pulses when it is 0. This holds for both transmit and receive.
- R3: A select value n picks `ovf_i[n]`. `tx_sel_i` picks the line for the transmitter and `rx_sel_i` picks the line for the receiver, each independently of the other.
- R4: `tx_done_o` becomes 1 on the same clock edge at which `tx_o` switches to the stop bit.
- R5: A frame starts only on a falling edge of `rx_i` seen while `rx_en_i` = 1. A frame sent while `rx_en_i` = 0 sets no flag.
- R6: A low pulse shorter than half a bit does not start a frame. Each bit is decided by a majority of three samples at mid-bit, so a one-cycle glitch at mid-bit does not change the received bit.
- R7: When a frame is committed, its data goes to `rx_data_o`, its sampled stop bit goes to `rx_stop_o`, and `rx_done_o` becomes 1.
- R8: A frame that ends while `rx_done_o` = 1 is dropped. `rx_data_o`, `rx_stop_o` and the flag stay unchanged.
- R9: When `strict_stop_i` = 1, a frame whose stop bit is low is dropped without setting the flag. When `strict_stop_i` = 0, such a frame is kept, with `rx_stop_o` = 0.
- R10: `tx_clr_i` clears `tx_done_o` and `rx_clr_i` clears `rx_done_o`. If a hardware set and a clear fall in the same cycle, the set wins. Both flags are 0 after reset.
- R11: `irq_o` is 1 exactly when `int_en_i` = 1 and at least one of `tx_done_o` and `rx_done_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ovf_i | input | NSRC (4) | Single-cycle overflow pulses from the reload timers |
| tx_sel_i | input | 2 | Overflow line used by the transmitter |
| rx_sel_i | input | 2 | Overflow line used by the receiver |
| speed_dbl_i | input | 1 | 1: bit = 16 overflows; 0: bit = 32 overflows |
| rx_en_i | input | 1 | Allows new receptions to start |
| strict_stop_i | input | 1 | Drop frames whose stop bit is low |
| int_en_i | input | 1 | Interrupt enable |
| tx_wr_i | input | 1 | Transmit buffer write strobe |
| tx_data_i | input | 8 | Byte to transmit |
| tx_clr_i | input | 1 | Clear strobe for the transmit-done flag |
| rx_clr_i | input | 1 | Clear strobe for the receive-done flag |
| rx_i | input | 1 | Serial receive line |
| tx_o | output | 1 | Serial transmit line |
| rx_data_o | output | 8 | Receive buffer |
| rx_stop_o | output | 1 | Stop bit of the last committed frame |
| tx_done_o | output | 1 | Transmit-done flag |
| rx_done_o | output | 1 | Receive-done flag |
| irq_o | output | 1 | Combined interrupt |

## Verification
The transmitter is driven with alternating and irregular bytes on different overflow lines at both divider settings. Bit-mid sampling shows the bit order. The exact length of one isolated high bit shows the divider setting and the chosen source apart. A bench-side line model feeds the receiver clean frames, frames with a one-cycle glitch at mid-bit, and a start pulse that is too short. It also sends frames with a low stop bit under both stop-check settings, frames that arrive while the flag is still set, and frames that arrive while reception is disabled. These cases separate a kept byte from a dropped one, and a true start from noise.

// File: rtl/tmr_uart_pkg.sv
package tmr_uart_pkg;
  localparam int DATA_W = 8;
  localparam int OSR    = 16;
  localparam int CNT_W  = $clog2(OSR);
  localparam int FRAME  = DATA_W + 2;
  localparam int IDX_W  = $clog2(FRAME);
  localparam int MID    = OSR / 2 - 1;
  typedef enum logic {ST_IDLE, ST_BUSY} st_e;
endpackage

// File: rtl/tmr_uart_tick.sv
module tmr_uart_tick #(
  parameter int NSRC = 4,
  localparam int SW = $clog2(NSRC)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [NSRC-1:0] ovf_i,
  input  logic [SW-1:0]   sel_i,
  input  logic            dbl_i,
  output logic            tick_o
);
  logic pick, half_q;
  assign pick   = ovf_i[sel_i];
  assign tick_o = pick && (dbl_i || half_q);

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)               half_q <= 1'b0;
    else if (pick && !dbl_i)   half_q <= ~half_q;

  // R2
  half_rate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_o && !dbl_i) |=> (!tick_o || dbl_i));
endmodule

// File: rtl/tmr_uart_tx.sv
module tmr_uart_tx
  import tmr_uart_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              tx_o,
  output logic              done_set_o
);
  st_e              st_q;
  logic [FRAME-1:0] sh_q;
  logic [IDX_W-1:0] idx_q;
  logic [CNT_W-1:0] sub_q;
  logic             bit_end;

  assign bit_end    = (st_q == ST_BUSY) && tick_i && (sub_q == CNT_W'(OSR - 1));
  assign done_set_o = bit_end && (idx_q == IDX_W'(DATA_W));
  assign tx_o       = (st_q == ST_BUSY) ? sh_q[0] : 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_IDLE;
      sh_q  <= '1;
      idx_q <= '0;
      sub_q <= '0;
    end else if (st_q == ST_IDLE) begin
      if (wr_i) begin
        st_q  <= ST_BUSY;
        sh_q  <= {1'b1, data_i, 1'b0};
        idx_q <= '0;
        sub_q <= '0;
      end
    end else if (tick_i) begin
      if (bit_end) begin
        sub_q <= '0;
        sh_q  <= {1'b1, sh_q[FRAME-1:1]};
        if (idx_q == IDX_W'(FRAME - 1)) st_q  <= ST_IDLE;
        else                            idx_q <= idx_q + 1'b1;
      end else begin
        sub_q <= sub_q + 1'b1;
      end
    end
  end

  // R1
  start_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && st_q == ST_IDLE) |=> !tx_o);
  // R4
  stop_edge_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_set_o |=> tx_o);
endmodule

// File: rtl/tmr_uart_rx.sv
module tmr_uart_rx
  import tmr_uart_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              rx_i,
  input  logic              en_i,
  input  logic              strict_i,
  input  logic              flag_i,
  output logic              commit_o,
  output logic [DATA_W-1:0] data_o,
  output logic              stop_o
);
  st_e               st_q;
  logic [2:0]        sync_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [IDX_W-1:0]  idx_q;
  logic [1:0]        votes_q;
  logic [DATA_W-1:0] sh_q;
  logic line, fall, busy_tick, capture, eval, vote;

  assign line      = sync_q[1];
  assign fall      = sync_q[2] && !sync_q[1];
  assign busy_tick = (st_q == ST_BUSY) && tick_i;
  assign capture   = busy_tick && (cnt_q >= CNT_W'(MID - 1)) && (cnt_q <= CNT_W'(MID + 1));
  assign eval      = busy_tick && (cnt_q == CNT_W'(MID + 1));
  assign vote      = (votes_q[1] & votes_q[0]) | (votes_q[1] & line) | (votes_q[0] & line);
  assign commit_o  = eval && (idx_q == IDX_W'(FRAME - 1)) && !flag_i && (!strict_i || vote);
  assign data_o    = sh_q;
  assign stop_o    = vote;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q  <= '1;
      st_q    <= ST_IDLE;
      cnt_q   <= '0;
      idx_q   <= '0;
      votes_q <= '0;
      sh_q    <= '0;
    end else begin
      sync_q <= {sync_q[1:0], rx_i};
      if (st_q == ST_IDLE) begin
        if (en_i && fall) begin
          st_q  <= ST_BUSY;
          cnt_q <= '0;
          idx_q <= '0;
        end
      end else if (tick_i) begin
        cnt_q <= cnt_q + 1'b1;
        if (cnt_q == CNT_W'(OSR - 1)) idx_q <= idx_q + 1'b1;
        if (capture) votes_q <= {votes_q[0], line};
        if (eval) begin
          if (idx_q == '0) begin
            if (vote) st_q <= ST_IDLE;    // false start
          end else if (idx_q == IDX_W'(FRAME - 1)) begin
            st_q <= ST_IDLE;              // free to catch the next edge
          end else begin
            sh_q <= {vote, sh_q[DATA_W-1:1]};
          end
        end
      end
    end
  end

  // R5
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_IDLE && !en_i) |=> st_q == ST_IDLE);
endmodule

// File: rtl/tmr_uart.sv
module tmr_uart
  import tmr_uart_pkg::*;
#(
  parameter int NSRC = 4,
  localparam int SW = $clog2(NSRC)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NSRC-1:0]   ovf_i,
  input  logic [SW-1:0]     tx_sel_i,
  input  logic [SW-1:0]     rx_sel_i,
  input  logic              speed_dbl_i,
  input  logic              rx_en_i,
  input  logic              strict_stop_i,
  input  logic              int_en_i,
  input  logic              tx_wr_i,
  input  logic [DATA_W-1:0] tx_data_i,
  input  logic              tx_clr_i,
  input  logic              rx_clr_i,
  input  logic              rx_i,
  output logic              tx_o,
  output logic [DATA_W-1:0] rx_data_o,
  output logic              rx_stop_o,
  output logic              tx_done_o,
  output logic              rx_done_o,
  output logic              irq_o
);
  logic tx_tick, rx_tick, tx_set, rx_commit, rx_stop_bit;
  logic [DATA_W-1:0] rx_byte;
  logic tx_done_q, rx_done_q, rx_stop_q;
  logic [DATA_W-1:0] rx_buf_q;

  tmr_uart_tick #(.NSRC(NSRC)) u_tx_tick (
    .clk_i, .rst_ni, .ovf_i, .sel_i(tx_sel_i), .dbl_i(speed_dbl_i), .tick_o(tx_tick));
  tmr_uart_tick #(.NSRC(NSRC)) u_rx_tick (
    .clk_i, .rst_ni, .ovf_i, .sel_i(rx_sel_i), .dbl_i(speed_dbl_i), .tick_o(rx_tick));

  tmr_uart_tx u_tx (
    .clk_i, .rst_ni, .tick_i(tx_tick), .wr_i(tx_wr_i), .data_i(tx_data_i),
    .tx_o, .done_set_o(tx_set));

  tmr_uart_rx u_rx (
    .clk_i, .rst_ni, .tick_i(rx_tick), .rx_i, .en_i(rx_en_i), .strict_i(strict_stop_i),
    .flag_i(rx_done_q), .commit_o(rx_commit), .data_o(rx_byte), .stop_o(rx_stop_bit));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_done_q <= 1'b0;
      rx_done_q <= 1'b0;
      rx_stop_q <= 1'b0;
      rx_buf_q  <= '0;
    end else begin
      if (tx_set)        tx_done_q <= 1'b1;
      else if (tx_clr_i) tx_done_q <= 1'b0;
      if (rx_commit) begin
        rx_done_q <= 1'b1;
        rx_buf_q  <= rx_byte;
        rx_stop_q <= rx_stop_bit;
      end else if (rx_clr_i) begin
        rx_done_q <= 1'b0;
      end
    end
  end

  assign tx_done_o = tx_done_q;
  assign rx_done_o = rx_done_q;
  assign rx_data_o = rx_buf_q;
  assign rx_stop_o = rx_stop_q;
  assign irq_o     = int_en_i && (tx_done_q || rx_done_q);

  // R10
  tx_set_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_set |=> tx_done_o);
  // R10
  rx_set_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_commit |=> rx_done_o);
  // R8
  rx_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_done_o && !rx_clr_i) |=> ($stable(rx_data_o) && $stable(rx_stop_o)));
  // R9
  strict_stop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_commit && strict_stop_i) |=> rx_stop_o);
endmodule

// File: tb/tmr_uart_bench.sv
`timescale 1ns/1ps
module tmr_uart_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] ovf = '0;
  logic [1:0] tx_sel = '0, rx_sel = '0;
  logic       dbl = 1'b1, rx_en = 1'b0, strict = 1'b0, int_en = 1'b0;
  logic       tx_wr = 1'b0, tx_clr = 1'b0, rx_clr = 1'b0, rx = 1'b1;
  logic [7:0] tx_data = '0;
  logic       tx, rx_stop, tx_done, rx_done, irq;
  logic [7:0] rx_data;

  int n_chk = 0, n_err = 0;
  int per [4] = '{3, 4, 5, 6};
  int ocnt [4] = '{0, 0, 0, 0};
  bit rec_tx [0:4095];
  bit rec_dn [0:4095];

  always #2.5 clk = ~clk;

  always @(negedge clk)
    for (int k = 0; k < 4; k++) begin
      if (ocnt[k] == per[k] - 1) begin ovf[k] = 1'b1; ocnt[k] = 0; end
      else begin ovf[k] = 1'b0; ocnt[k]++; end
    end

  tmr_uart u_tmr_uart (
    .clk_i(clk), .rst_ni(rst_n), .ovf_i(ovf), .tx_sel_i(tx_sel), .rx_sel_i(rx_sel),
    .speed_dbl_i(dbl), .rx_en_i(rx_en), .strict_stop_i(strict), .int_en_i(int_en),
    .tx_wr_i(tx_wr), .tx_data_i(tx_data), .tx_clr_i(tx_clr), .rx_clr_i(rx_clr),
    .rx_i(rx), .tx_o(tx), .rx_data_o(rx_data), .rx_stop_o(rx_stop),
    .tx_done_o(tx_done), .rx_done_o(rx_done), .irq_o(irq));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int bit_time(input int sel, input bit d);
    return 16 * (d ? 1 : 2) * per[sel];
  endfunction

  task automatic pulse_clr(input bit t, input bit r);
    @(negedge clk); tx_clr = t; rx_clr = r;
    @(negedge clk); tx_clr = 1'b0; rx_clr = 1'b0;
  endtask

  task automatic t_reset;
    chk(tx == 1'b1, "R1 idle line", tx, 1);
    chk(tx_done == 1'b0 && rx_done == 1'b0, "R10 flags after reset", {tx_done, rx_done}, 0);
    chk(irq == 1'b0, "R11 irq after reset", irq, 0);
  endtask

  task automatic t_tx(input logic [7:0] b, input int sel, input bit d);
    int bt, n, rise, len;
    logic [7:0] got;
    tx_sel = 2'(sel); dbl = d;
    bt = bit_time(sel, d);
    @(negedge clk); tx_data = b; tx_wr = 1'b1;
    @(negedge clk); tx_wr = 1'b0;
    for (int i = 0; i < 11 * bt; i++) begin
      rec_tx[i] = tx; rec_dn[i] = tx_done;
      @(negedge clk);
    end
    chk(rec_tx[0] == 1'b0, "R1 start bit low after write", rec_tx[0], 0);
    for (int k = 0; k < 8; k++) got[k] = rec_tx[(k + 1) * bt + bt / 2];
    chk(got == b, "R1 data bits lsb first", got, b);
    chk(rec_tx[9 * bt + bt / 2] == 1'b1, "R1 stop bit high", rec_tx[9 * bt + bt / 2], 1);
    n = 0;
    while (n < 11 * bt - 1 && !rec_dn[n]) n++;
    chk(n > 8 * bt && n < 9 * bt + bt / 2 && rec_tx[n] && rec_tx[n - 1] == b[7],
        "R4 done flag at stop start", n, 9 * bt);
    if (b[0] && !b[1]) begin
      rise = 1;
      while (rise < 11 * bt && rec_tx[rise] == 1'b0) rise++;
      len = 0;
      while (rise + len < 11 * bt && rec_tx[rise + len]) len++;
      chk(len == bt, "R2 R3 bit length in cycles", len, bt);
    end
    chk(tx_done == 1'b1, "R4 done flag held", tx_done, 1);
    pulse_clr(1'b1, 1'b0);
    chk(tx_done == 1'b0, "R10 tx flag cleared", tx_done, 0);
  endtask

  task automatic send_line(input logic [7:0] b, input bit stopv, input int bt, input int glitch);
    logic [9:0] fr;
    fr = {stopv, b, 1'b0};
    for (int k = 0; k < 10; k++)
      for (int c = 0; c < bt; c++) begin
        @(negedge clk);
        rx = fr[k];
        if (k == glitch && c == bt / 2) rx = ~fr[k];
      end
    @(negedge clk); rx = 1'b1;
    repeat (bt) @(negedge clk);
  endtask

  task automatic t_rx(input logic [7:0] b, input bit stopv, input int sel, input bit d,
                      input int glitch, input bit exp_flag, input logic [7:0] exp_data,
                      input bit exp_stop, input string req);
    rx_sel = 2'(sel); dbl = d;
    send_line(b, stopv, bit_time(sel, d), glitch);
    chk(rx_done == exp_flag, {req, " flag"}, rx_done, exp_flag);
    chk(rx_data == exp_data, {req, " data"}, rx_data, exp_data);
    chk(rx_stop == exp_stop, {req, " stop status"}, rx_stop, exp_stop);
  endtask

  task automatic t_short_start;
    int bt;
    rx_sel = 2'd2; dbl = 1'b1; bt = bit_time(2, 1'b1);
    @(negedge clk); rx = 1'b0;
    repeat (bt / 4) @(negedge clk);
    rx = 1'b1;
    repeat (2 * bt) @(negedge clk);
    chk(rx_done == 1'b0, "R6 short low pulse ignored", rx_done, 0);
  endtask

  task automatic t_irq;
    int_en = 1'b0; @(negedge clk);
    chk(irq == 1'b0, "R11 irq masked", irq, 0);
    int_en = 1'b1; @(negedge clk);
    chk(irq == 1'b1, "R11 irq with rx flag", irq, 1);
  endtask

  task automatic finish_run;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_tx(8'h55, 0, 1'b1);
    t_tx(8'h55, 3, 1'b0);
    t_tx(8'hC3, 2, 1'b1);
    t_tx(8'h96, 1, 1'b0);
    rx_en = 1'b1;
    t_rx(8'hA5, 1'b1, 2, 1'b1, -1, 1'b1, 8'hA5, 1'b1, "R7 R3 commit");
    t_irq();
    int_en = 1'b0;
    t_rx(8'h99, 1'b1, 2, 1'b1, -1, 1'b1, 8'hA5, 1'b1, "R8 drop while flag set");
    pulse_clr(1'b0, 1'b1);
    chk(rx_done == 1'b0, "R10 rx flag cleared", rx_done, 0);
    t_rx(8'h3C, 1'b1, 1, 1'b0, 4, 1'b1, 8'h3C, 1'b1, "R6 R2 glitch vote at half speed");
    pulse_clr(1'b0, 1'b1);
    strict = 1'b1;
    t_rx(8'h5A, 1'b0, 0, 1'b1, -1, 1'b0, 8'h3C, 1'b1, "R9 strict rejects low stop");
    strict = 1'b0;
    t_rx(8'h5A, 1'b0, 0, 1'b1, -1, 1'b1, 8'h5A, 1'b0, "R9 relaxed keeps low stop");
    pulse_clr(1'b0, 1'b1);
    rx_en = 1'b0;
    t_rx(8'h81, 1'b1, 3, 1'b1, -1, 1'b0, 8'h5A, 1'b0, "R5 disabled receiver");
    rx_en = 1'b1;
    t_short_start();
    t_rx(8'h7E, 1'b1, 2, 1'b1, -1, 1'b1, 8'h7E, 1'b1, "R6 R5 frame after noise");
    pulse_clr(1'b0, 1'b1);
    int_en = 1'b1; @(negedge clk);
    chk(irq == 1'b0, "R11 irq low with flags clear", irq, 0);
    finish_run();
  end
endmodule